// File: doc/BRIEF.md
# Multi-cycle instruction sequencer

This block is the control core of a small load/store processor. It holds the program counter, the memory address and memory buffer registers, the instruction register and a sixteen-entry register file. It steps each instruction through fixed time slots: a four-slot fetch, then an execute phase whose length depends on the instruction class. In each slot it drives at most one transfer. Memory is reached through a read/write request that is held until the memory answers with a ready strobe.

Arithmetic is done outside the block. The sequencer presents two operands and a function code, takes the result back into the destination register, and raises a one-slot flag-update strobe when the instruction asks for flags. The zero and negative flags come back as condition inputs for the conditional branches.

Instruction word layout: opcode in bits 31:28, set-flags in bit 27, literal-select in bit 26, destination (or store source) register in bits 23:20, first source in 19:16, second source in 15:12, literal in 11:0, memory address in 15:0, and branch target in 23:0.

Top module: `cpu_sequencer`

## Requirements
- R1: While reset is asserted, no memory request is raised. Reset clears the program counter, and the first access after reset is an instruction read at address 0, completed in the second slot after release when memory has no wait.
- R2: Fetch takes four slots. The address register takes the program counter, the counter then advances by 4, the word is read into the buffer, and then the buffer is moved into the instruction register. A register, literal, branch or no-op instruction takes 5 + w cycles in total, where w is the number of wait cycles memory adds.
- R3: Opcodes 0, 1, 2 and 3 (add, subtract, and, or) drive the first source register on operand A and drive the opcode's low two bits as the function code. Operand B is the second source register, or the zero-extended literal when bit 26 is 1. The result is written to the destination register in the execute slot.
- R4: The flag-update strobe is high for exactly one slot, during the execute slot of an opcode 0 to 3 with bit 27 set, and at no other time.
- R5: Opcode 4 writes the zero-extended 12-bit literal into the destination register without any memory access.
- R6: Opcode 5 loads the destination register from the zero-extended address in bits 15:0. It reads in its own slot and writes back in the next, and the instruction takes 7 + 2w cycles.
- R7: Opcode 6 writes the register named in bits 23:20 to the zero-extended address in bits 15:0, and takes 7 + 2w cycles.
- R8: Opcode 8 always loads the program counter with the zero-extended bits 23:0.
- R9: Opcode 9 branches only when the zero flag is 1. Opcode 10 branches only when the negative flag is 0. When the branch is not taken, the next sequential word is fetched.
- R10: A memory request keeps its direction and address stable until ready is seen. Read and write are never high together. The address shown is the memory address register, and the write data is the buffer.
- R11: Opcodes 7 and 11 to 15 change no register and make no memory access, and take 5 + w cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | DW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory completes the current request |
| mem_rdata | input | DW | Memory read data |
| alu_fn | output | 2 | Arithmetic function code |
| alu_a | output | DW | Operand A |
| alu_b | output | DW | Operand B |
| alu_y | input | DW | Arithmetic result |
| flag_upd | output | 1 | Strobe to capture the result flags |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |

## Verification
The bench builds the block with its default data width of 32 and a program-counter step of 4. It runs one program twice, once with zero-wait memory and once with two wait cycles per access. The waited run exercises the request hold and the 2w term of load and store timing. The program covers a countdown loop that exits on the zero flag, a literal at its 12-bit maximum, a flag-setting result that turns negative, a branch on plus both skipped and taken, an instruction without set-flags that must leave a stale negative flag in place, and an undefined opcode. Every completed access is compared in order against a behavioural model, and so is the cycle distance between instruction reads.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

    localparam int IW     = 32;
    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);
    localparam int LIT_W  = 12;
    localparam int ADR_W  = 16;
    localparam int TGT_W  = 24;

    typedef enum logic [3:0] {
        S_FMAR, S_FINC, S_FRD, S_FIR, S_EXEC,
        S_LRD, S_LWB, S_SMBR, S_SWR
    } seq_state_e;

    typedef enum logic [2:0] {
        K_ALU, K_MOV, K_LDR, K_STR, K_BR, K_NOP
    } iclass_e;

    typedef enum logic [1:0] {
        BC_ALWAYS, BC_EQ, BC_PL, BC_NEVER
    } bcond_e;

    typedef struct packed {
        iclass_e            cls;
        logic               set_fl;
        logic               lit_sel;
        logic [1:0]         fn;
        logic [RIDX_W-1:0]  rd;
        logic [RIDX_W-1:0]  rs1;
        logic [RIDX_W-1:0]  rs2;
        logic [LIT_W-1:0]   lit;
        logic [ADR_W-1:0]   addr;
        logic [TGT_W-1:0]   tgt;
        bcond_e             cond;
    } idec_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import cpu_seq_pkg::*;
(
    input  logic [IW-1:0] ir,
    output idec_t         dec
);
    always_comb begin
        dec.cls     = K_NOP;
        dec.cond    = BC_NEVER;
        dec.fn      = ir[29:28];
        dec.set_fl  = ir[27];
        dec.lit_sel = ir[26];
        dec.rd      = ir[23:20];
        dec.rs1     = ir[19:16];
        dec.rs2     = ir[15:12];
        dec.lit     = ir[LIT_W-1:0];
        dec.addr    = ir[ADR_W-1:0];
        dec.tgt     = ir[TGT_W-1:0];
        case (ir[31:28])
            4'h0, 4'h1, 4'h2, 4'h3: dec.cls = K_ALU;
            4'h4: dec.cls = K_MOV;
            4'h5: dec.cls = K_LDR;
            4'h6: dec.cls = K_STR;
            4'h8: begin dec.cls = K_BR; dec.cond = BC_ALWAYS; end
            4'h9: begin dec.cls = K_BR; dec.cond = BC_EQ;     end
            4'hA: begin dec.cls = K_BR; dec.cond = BC_PL;     end
            default: dec.cls = K_NOP;
        endcase
    end
endmodule

// File: rtl/seq_branch_eval.sv
module seq_branch_eval
    import cpu_seq_pkg::*;
(
    input  bcond_e cond,
    input  logic   flag_z,
    input  logic   flag_n,
    output logic   take
);
    always_comb begin
        case (cond)
            BC_ALWAYS: take = 1'b1;
            BC_EQ:     take = flag_z;
            BC_PL:     take = ~flag_n;
            default:   take = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpu_sequencer.sv
module cpu_sequencer
    import cpu_seq_pkg::*;
#(
    parameter int DW      = 32,
    parameter int PC_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic [1:0]    alu_fn,
    output logic [DW-1:0] alu_a,
    output logic [DW-1:0] alu_b,
    input  logic [DW-1:0] alu_y,
    output logic          flag_upd,
    input  logic          flag_z,
    input  logic          flag_n
);
    localparam logic [DW-1:0] STEP = DW'(PC_STEP);

    typedef struct packed {
        seq_state_e                st;
        logic [DW-1:0]             pc;
        logic [DW-1:0]             mar;
        logic [DW-1:0]             mbr;
        logic [IW-1:0]             ir;
        logic [NREG-1:0][DW-1:0]   rf;
    } core_t;

    core_t core_q, core_d;
    idec_t dec;
    logic  take;

    seq_decode u_dec (
        .ir  (core_q.ir),
        .dec (dec)
    );

    seq_branch_eval u_br (
        .cond   (dec.cond),
        .flag_z (flag_z),
        .flag_n (flag_n),
        .take   (take)
    );

    always_comb begin
        core_d = core_q;
        case (core_q.st)
            S_FMAR: begin
                core_d.mar = core_q.pc;
                core_d.st  = S_FINC;
            end
            S_FINC: begin
                core_d.pc = core_q.pc + STEP;
                core_d.st = S_FRD;
            end
            S_FRD: begin
                if (mem_ready) begin
                    core_d.mbr = mem_rdata;
                    core_d.st  = S_FIR;
                end
            end
            S_FIR: begin
                core_d.ir = core_q.mbr[IW-1:0];
                core_d.st = S_EXEC;
            end
            S_EXEC: begin
                core_d.st = S_FMAR;
                case (dec.cls)
                    K_ALU: core_d.rf[dec.rd] = alu_y;
                    K_MOV: core_d.rf[dec.rd] = DW'(dec.lit);
                    K_LDR: begin
                        core_d.mar = DW'(dec.addr);
                        core_d.st  = S_LRD;
                    end
                    K_STR: begin
                        core_d.mar = DW'(dec.addr);
                        core_d.st  = S_SMBR;
                    end
                    K_BR: if (take) core_d.pc = DW'(dec.tgt);
                    default: ;
                endcase
            end
            S_LRD: begin
                if (mem_ready) begin
                    core_d.mbr = mem_rdata;
                    core_d.st  = S_LWB;
                end
            end
            S_LWB: begin
                core_d.rf[dec.rd] = core_q.mbr;
                core_d.st         = S_FMAR;
            end
            S_SMBR: begin
                core_d.mbr = core_q.rf[dec.rd];
                core_d.st  = S_SWR;
            end
            S_SWR: begin
                if (mem_ready) core_d.st = S_FMAR;
            end
            default: core_d.st = S_FMAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q    <= '0;
            core_q.st <= S_FMAR;
        end else begin
            core_q <= core_d;
        end
    end

    assign mem_rd    = (core_q.st == S_FRD) || (core_q.st == S_LRD);
    assign mem_wr    = (core_q.st == S_SWR);
    assign mem_addr  = core_q.mar;
    assign mem_wdata = core_q.mbr;
    assign alu_fn    = dec.fn;
    assign alu_a     = core_q.rf[dec.rs1];
    assign alu_b     = dec.lit_sel ? DW'(dec.lit) : core_q.rf[dec.rs2];
    assign flag_upd  = (core_q.st == S_EXEC) && (dec.cls == K_ALU) && dec.set_fl;

endmodule

// File: rtl/seq_check.sv
module seq_check #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          mem_ready,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          flag_upd
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!mem_rd && !mem_wr);
        end
    end

    a_r10_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r10_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    a_r10_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    a_r2_slot_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_ready) |=> (!mem_rd && !mem_wr));

    a_r7_slot_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_ready) |=> (!mem_rd && !mem_wr));

    a_r4_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd |=> !flag_upd);

    a_r4_no_flag_during_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !flag_upd);
endmodule

bind cpu_sequencer seq_check #(.DW(DW)) u_seq_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .flag_upd  (flag_upd)
);

// File: tb/cpu_sequencer_test.sv
module cpu_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALT_PC    = 32'h5C;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd, mem_wr, mem_ready = 1'b0, flag_upd;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [1:0]  alu_fn;
    logic [31:0] alu_a, alu_b, alu_y;
    logic        fz, fn_;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_sequencer #(.DW(32), .PC_STEP(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .alu_fn(alu_fn), .alu_a(alu_a), .alu_b(alu_b), .alu_y(alu_y),
        .flag_upd(flag_upd), .flag_z(fz), .flag_n(fn_)
    );

    int total = 0, bad = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // external arithmetic unit and flag register
    always_comb begin
        case (alu_fn)
            2'd0: alu_y = alu_a + alu_b;
            2'd1: alu_y = alu_a - alu_b;
            2'd2: alu_y = alu_a & alu_b;
            default: alu_y = alu_a | alu_b;
        endcase
    end

    int cyc = 0, total_cyc = 0, fl_cnt = 0;
    always @(posedge clk) begin
        total_cyc++;
        if (!rst_n) begin
            cyc = 0; fz <= 1'b0; fn_ <= 1'b0;
        end else begin
            cyc++;
            if (flag_upd) begin
                fl_cnt++;
                fz  <= (alu_y == 32'd0);
                fn_ <= alu_y[31];
            end
        end
    end

    // memory images: dm for the design, rm for the model
    logic [31:0] dm [int];
    logic [31:0] rm [int];

    function automatic logic [31:0] e_alu(int op, bit s, bit l, int rd, int rs1, int rs2, int lit);
        return {op[3:0], s, l, 2'b00, rd[3:0], rs1[3:0], rs2[3:0], lit[11:0]};
    endfunction
    function automatic logic [31:0] e_mem(int op, int rd, int adr);
        return {op[3:0], 4'h0, rd[3:0], 4'h0, adr[15:0]};
    endfunction
    function automatic logic [31:0] e_br(int op, int tgt);
        return {op[3:0], 4'h0, tgt[23:0]};
    endfunction

    task automatic put(input int a, input logic [31:0] v);
        dm[a] = v; rm[a] = v;
    endtask

    task automatic init_mems;
        dm.delete(); rm.delete();
        put(32'h00, e_alu(4, 0, 0, 1, 0, 0, 3));        // MOV r1,3
        put(32'h04, e_alu(4, 0, 0, 2, 0, 0, 12'hFFF));  // MOV r2,max literal
        put(32'h08, e_alu(0, 0, 0, 3, 1, 2, 0));        // ADD r3,r1,r2
        put(32'h0C, e_alu(1, 1, 1, 1, 1, 0, 1));        // SUBS r1,r1,#1
        put(32'h10, e_br(9, 32'h1C));                   // BEQ
        put(32'h14, e_mem(6, 1, 32'h400));              // STR r1
        put(32'h18, e_br(8, 32'h0C));                   // B loop
        put(32'h1C, e_alu(1, 1, 0, 4, 4, 2, 0));        // SUBS r4,r4,r2
        put(32'h20, e_br(10, 32'h28));                  // BPL not taken
        put(32'h24, e_mem(6, 4, 32'h404));
        put(32'h28, e_alu(3, 0, 0, 5, 3, 2, 0));        // ORR no flags
        put(32'h2C, e_br(10, 32'h38));                  // BPL, stale N
        put(32'h30, e_alu(0, 1, 1, 6, 1, 0, 7));        // ADDS r6,r1,#7
        put(32'h34, e_br(10, 32'h3C));                  // BPL taken
        put(32'h38, e_mem(6, 5, 32'h408));              // skipped
        put(32'h3C, e_mem(5, 7, 32'h400));              // LDR r7
        put(32'h40, e_mem(6, 7, 32'h40C));
        put(32'h44, e_alu(2, 0, 0, 9, 3, 2, 0));        // AND
        put(32'h48, e_mem(6, 9, 32'h410));
        put(32'h4C, e_mem(5, 10, 32'h500));
        put(32'h50, e_mem(6, 10, 32'h414));
        put(32'h54, 32'hFF22_0418);                     // undefined opcode
        put(32'h58, e_mem(6, 2, 32'h418));
        put(HALT_PC, e_br(8, HALT_PC));
        put(32'h500, 32'hA5A5_1234);
    endtask

    function automatic logic [31:0] rd_img(ref logic [31:0] m [int], input logic [31:0] a);
        if (m.exists(int'(a))) return m[int'(a)];
        return 32'd0;
    endfunction

    // expected completed accesses, in order
    bit          q_wr [$];
    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];
    int          q_delta [$];
    string       q_tag [$];
    string       q_dtag [$];
    int          exp_flags;

    task automatic push(bit w, logic [31:0] a, logic [31:0] d, int dl, string t, string dt);
        q_wr.push_back(w); q_addr.push_back(a); q_data.push_back(d);
        q_delta.push_back(dl); q_tag.push_back(t); q_dtag.push_back(dt);
    endtask

    task automatic build_expect(input int w);
        logic [31:0] regs [16];
        logic [31:0] pc, npc, ir, b, y, a;
        bit z, n;
        int cost, halts;
        string tag, dtag;
        foreach (regs[i]) regs[i] = '0;
        pc = 0; z = 0; n = 0; halts = 0; exp_flags = 0;
        cost = 2 + w; tag = "R1"; dtag = "R1";
        q_wr.delete(); q_addr.delete(); q_data.delete();
        q_delta.delete(); q_tag.delete(); q_dtag.delete();
        for (int step = 0; step < 200; step++) begin
            ir = rd_img(rm, pc);
            push(1'b0, pc, ir, cost, tag, dtag);
            if (pc == HALT_PC) begin
                if (halts == 1) break;
                halts++;
            end
            npc = pc + 4; cost = 5 + w; dtag = "R2";
            case (ir[31:28])
                4'h0, 4'h1, 4'h2, 4'h3: begin
                    b = ir[26] ? {20'd0, ir[11:0]} : regs[ir[15:12]];
                    a = regs[ir[19:16]];
                    case (ir[29:28])
                        2'd0: y = a + b;
                        2'd1: y = a - b;
                        2'd2: y = a & b;
                        default: y = a | b;
                    endcase
                    regs[ir[23:20]] = y;
                    if (ir[27]) begin z = (y == 0); n = y[31]; exp_flags++; end
                    tag = "R3";
                end
                4'h4: begin regs[ir[23:20]] = {20'd0, ir[11:0]}; tag = "R5"; end
                4'h5: begin
                    a = {16'd0, ir[15:0]};
                    y = rd_img(rm, a);
                    push(1'b0, a, y, -1, "R6", "R6");
                    regs[ir[23:20]] = y; cost = 7 + 2*w; tag = "R6"; dtag = "R6";
                end
                4'h6: begin
                    a = {16'd0, ir[15:0]};
                    push(1'b1, a, regs[ir[23:20]], -1, "R7", "R7");
                    rm[int'(a)] = regs[ir[23:20]];
                    cost = 7 + 2*w; tag = "R7"; dtag = "R7";
                end
                4'h8: begin npc = {8'd0, ir[23:0]}; tag = "R8"; end
                4'h9: begin if (z) npc = {8'd0, ir[23:0]}; tag = "R9"; end
                4'hA: begin if (!n) npc = {8'd0, ir[23:0]}; tag = "R9"; end
                default: begin tag = "R11"; dtag = "R11"; end
            endcase
            pc = npc;
        end
    endtask

    // memory responder and access monitor
    int wait_n = 0, wcnt = 0, last_fetch = 0;
    bit phase_done = 0, hold_act = 0, hold_wr = 0;
    logic [31:0] hold_addr;

    task automatic check_access;
        bit w; logic [31:0] a, d; int dl; string t, dt;
        if (q_wr.size() == 0) begin
            check(1'b0, "R10", "unexpected access addr", mem_addr, 32'hFFFF_FFFF);
            return;
        end
        w = q_wr.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
        dl = q_delta.pop_front(); t = q_tag.pop_front(); dt = q_dtag.pop_front();
        check(mem_wr == w, t, "direction", {31'd0, mem_wr}, {31'd0, w});
        check(mem_addr == a, t, "address", mem_addr, a);
        if (w) check(mem_wdata == d, t, "write data", mem_wdata, d);
        if (dl >= 0) begin
            check(cyc - last_fetch == dl, dt, "cycles between fetches",
                  32'(cyc - last_fetch), 32'(dl));
            last_fetch = cyc;
        end
        if (q_wr.size() == 0) phase_done = 1;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 0; wcnt = 0; hold_act = 0; last_fetch = 0;
        end else begin
            if (hold_act) begin
                check((mem_rd || mem_wr) && mem_wr == hold_wr && mem_addr == hold_addr,
                      "R10", "request held while waiting", mem_addr, hold_addr);
                hold_act = 0;
            end
            if (mem_rd || mem_wr) begin
                mem_rdata = rd_img(dm, mem_addr);
                if (wcnt == wait_n) begin
                    mem_ready = 1; wcnt = 0;
                    check_access();
                    if (mem_wr) dm[int'(mem_addr)] = mem_wdata;
                end else begin
                    mem_ready = 0; wcnt++;
                    hold_act = 1; hold_wr = mem_wr; hold_addr = mem_addr;
                end
            end else begin
                mem_ready = 0; wcnt = 0;
            end
        end
    end

    initial begin
        for (int ph = 0; ph < 2; ph++) begin
            wait_n = ph * 2;
            init_mems();
            build_expect(wait_n);
            phase_done = 0;
            fl_cnt = 0;
            @(negedge clk); #1 rst_n = 0;
            repeat (3) begin
                @(negedge clk); #1;
                check(!mem_rd && !mem_wr, "R1", "no request in reset",
                      {30'd0, mem_rd, mem_wr}, 32'd0);
            end
            rst_n = 1;
            wait (phase_done || total_cyc > WD_LIMIT);
            if (total_cyc > WD_LIMIT) begin
                check(1'b0, "R10", "watchdog expired", 32'(total_cyc), 32'(WD_LIMIT));
                break;
            end
            @(negedge clk); #1;
            check(fl_cnt == exp_flags, "R4", "flag strobe count", 32'(fl_cnt), 32'(exp_flags));
            check(rd_img(dm, 32'h408) == 32'd0, "R9", "skipped store left memory",
                  rd_img(dm, 32'h408), 32'd0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule